// File: doc/BRIEF.md
# Mailbox command request sequencer

This block runs one command exchange between a host and a coprocessor. The two sides share a small message RAM and a pair of mailbox registers. A one-cycle start pulse carries a command index. The block then does the following in order:

1. It writes a fixed five-word request into the message RAM.
2. It rings the doorbell toward the coprocessor.
3. It polls the reply mailbox until a nonzero value appears or the poll budget is used up.
4. It fetches the five reply words and clears the reply mailbox.
5. It reports a compact status code and decodes where the reply's data lives.

All traffic goes through one simple register/RAM port:

- `bus_valid` marks an access.
- `bus_write` selects a write.
- `bus_addr` is a byte address.
- Read data comes back combinationally in the same cycle as the read request.

The coprocessor and the RAMs are outside the block. Software or a higher-level engine pulses `start` and waits for `done`. Then it takes `status` and the decoded location (`rep_msgram`, `rep_addr`, `rep_fatal`), which stay valid until the next `done`.

Top module: `mbox_cmd_seq`

## Requirements
- R1: A start pulse is accepted only while `busy` is low. `busy` rises in the cycle after an accepted start. A start that arrives while `busy` is high has no effect on the bus traffic or on the number of `done` pulses.
- R2: A command index of 3 or more is rejected. There is no bus access, `done` is due 2 cycles after the start edge, and `status` is 2.
- R3: Index 0, 1 and 2 each write five words to byte addresses 0x100, 0x104, 0x108, 0x10C and 0x110, in that order. The words are header, command, argument count, argument, checksum:
  - index 0 writes {1,1,1,1,4}
  - index 1 writes {1,2,1,1,5}
  - index 2 writes {1,2,1,2,6}
- R4: Directly after the fifth word, the value 1 is written to the doorbell at byte address 0x10.
- R5: The reply mailbox at byte address 0x14 is then read. A nonzero value ends the wait. A zero value is followed by `POLL_GAP` idle cycles and then another read.
- R6: After `POLL_MAX` zero reads the exchange times out. No reply word is read and `status` is 5.
- R7: Whether the wait ends by reply or by timeout, the value 0 is written to address 0x14 as the last bus access of the exchange.
- R8: After a nonzero mailbox value, the five reply words are read from 0x100 to 0x110 in ascending order.
- R9: Status is decided in this order:
  - A reply whose fifth word differs from the 32-bit sum of its first four words gives status 3, whatever the mailbox value.
  - Otherwise, a mailbox value of 1 gives status 0.
  - Otherwise, status is one plus the index of the lowest set bit among bits 30..0, or 0 if none of them is set.
  - As a result, the error codes with bit 31 set plus bit 0, 1, 2, 3 or 4 give status 1, 2, 3, 4 and 5.
- R10: When status is 0, the reply's argument word (fourth word) is decoded. Bits 31:28 are a type and bits 27:0 are an offset:
  - type 1 sets `rep_msgram` and gives `rep_addr` = 0x100 + offset
  - type 0 clears `rep_msgram` and gives `rep_addr` = offset
  - any other type sets `rep_fatal`

  When status is not 0, all three decode outputs are 0.
- R11: `done` is a one-cycle pulse. `status` and the decode outputs hold their values until the next `done`. With the start edge counted as cycle 0, `done` is due in cycle 15 + d·(1+`POLL_GAP`) for a reply seen on poll d+1, and in cycle 10 + (`POLL_MAX`−1)·(1+`POLL_GAP`) on timeout.
- R12: While `busy` is low, `bus_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an exchange (one-cycle pulse) |
| cmd_idx | input | 4 | Command index; 0..2 valid |
| bus_valid | output | 1 | Bus access this cycle |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid in the cycle of the read |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 5 | Result code (0 = success) |
| rep_msgram | output | 1 | Reply data lies in the message RAM |
| rep_fatal | output | 1 | Reply location type was unrecognised |
| rep_addr | output | 32 | Decoded byte address of the reply data |

## Verification
Every result of this block is due a fixed, computable number of cycles after the start edge:

- a rejected index finishes in cycle 2
- a reply seen on poll d+1 finishes in cycle 15 + d·(1+`POLL_GAP`)
- a timeout finishes in cycle 10 + (`POLL_MAX`−1)·(1+`POLL_GAP`)

The bench counts falling edges from the start edge and requires `done` in exactly that cycle. It reads `status` and the decode outputs there, and checks that nothing changed before it. The bus is logged at rising edges by a coprocessor model. After each exchange, the bench compares the counts and order of writes, message reads and polls with the sequence the requirements call for.

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq #(
  parameter int ADDR_W   = 12,
  parameter int MSG_BASE = 'h100,
  parameter int DB_OFF   = 'h10,
  parameter int HM_OFF   = 'h14,
  parameter int POLL_MAX = 200000,
  parameter int POLL_GAP = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        cmd_idx,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              done,
  output logic [4:0]        status,
  output logic              rep_msgram,
  output logic              rep_fatal,
  output logic [31:0]       rep_addr
);

  localparam int PCNT_W = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam int GCNT_W = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam logic [PCNT_W-1:0] PLAST = PCNT_W'(POLL_MAX - 1);
  localparam logic [GCNT_W-1:0] GLAST = GCNT_W'((POLL_GAP > 0) ? POLL_GAP - 1 : 0);

  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_RING, S_POLL, S_WAIT, S_RD, S_CLR, S_EVAL
  } st_t;

  st_t               st;
  logic [2:0]        widx;
  logic [1:0]        cmd_q;
  logic              rej_q, tout_q;
  logic [31:0]       resp_q;
  logic [31:0]       rw [5];
  logic [PCNT_W-1:0] pcnt;
  logic [GCNT_W-1:0] gcnt;

  function automatic logic [31:0] req_word(input logic [1:0] c, input logic [2:0] i);
    case (i)
      3'd1:    req_word = (c == 2'd0) ? 32'd1 : 32'd2;
      3'd3:    req_word = (c == 2'd2) ? 32'd2 : 32'd1;
      3'd4:    req_word = 32'd4 + 32'(c);
      default: req_word = 32'd1;
    endcase
  endfunction

  function automatic logic [4:0] low_flag(input logic [31:0] v);
    low_flag = 5'd0;
    for (int i = 30; i >= 0; i--)
      if (v[i]) low_flag = 5'(i + 1);
  endfunction

  wire [ADDR_W-1:0] word_addr = ADDR_W'(MSG_BASE) + ADDR_W'({widx, 2'b00});
  wire [31:0]       sum4      = rw[0] + rw[1] + rw[2] + rw[3];
  wire [4:0]        code      = tout_q            ? 5'd5 :
                                rej_q             ? 5'd2 :
                                (sum4 != rw[4])   ? 5'd3 :
                                (resp_q == 32'd1) ? 5'd0 : low_flag(resp_q);
  wire [3:0]        loc_type  = rw[3][31:28];
  wire [31:0]       loc_off   = {4'd0, rw[3][27:0]};

  assign busy = (st != S_IDLE);

  always_comb begin
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_WR:   begin bus_valid = 1'b1; bus_write = 1'b1; bus_addr = word_addr; bus_wdata = req_word(cmd_q, widx); end
      S_RING: begin bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ADDR_W'(DB_OFF); bus_wdata = 32'd1; end
      S_POLL: begin bus_valid = 1'b1; bus_addr = ADDR_W'(HM_OFF); end
      S_RD:   begin bus_valid = 1'b1; bus_addr = word_addr; end
      S_CLR:  begin bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ADDR_W'(HM_OFF); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      widx       <= '0;
      cmd_q      <= '0;
      rej_q      <= 1'b0;
      tout_q     <= 1'b0;
      resp_q     <= '0;
      pcnt       <= '0;
      gcnt       <= '0;
      done       <= 1'b0;
      status     <= '0;
      rep_msgram <= 1'b0;
      rep_fatal  <= 1'b0;
      rep_addr   <= '0;
      for (int i = 0; i < 5; i++) rw[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cmd_q  <= cmd_idx[1:0];
          rej_q  <= (cmd_idx > 4'd2);
          tout_q <= 1'b0;
          widx   <= '0;
          pcnt   <= '0;
          st     <= (cmd_idx > 4'd2) ? S_EVAL : S_WR;
        end
        S_WR: begin
          widx <= widx + 3'd1;
          if (widx == 3'd4) st <= S_RING;
        end
        S_RING: st <= S_POLL;
        S_POLL: begin
          if (bus_rdata != 32'd0) begin
            resp_q <= bus_rdata;
            widx   <= '0;
            st     <= S_RD;
          end else if (pcnt == PLAST) begin
            tout_q <= 1'b1;
            st     <= S_CLR;
          end else begin
            pcnt <= pcnt + 1'b1;
            gcnt <= '0;
            st   <= (POLL_GAP > 0) ? S_WAIT : S_POLL;
          end
        end
        S_WAIT: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == GLAST) st <= S_POLL;
        end
        S_RD: begin
          rw[widx] <= bus_rdata;
          widx     <= widx + 3'd1;
          if (widx == 3'd4) st <= S_CLR;
        end
        S_CLR: st <= S_EVAL;
        S_EVAL: begin
          done       <= 1'b1;
          status     <= code;
          rep_msgram <= 1'b0;
          rep_fatal  <= 1'b0;
          rep_addr   <= '0;
          if (code == 5'd0) begin
            if (loc_type == 4'd1) begin
              rep_msgram <= 1'b1;
              rep_addr   <= 32'(MSG_BASE) + loc_off;
            end else if (loc_type == 4'd0) begin
              rep_addr   <= loc_off;
            end else begin
              rep_fatal  <= 1'b1;
            end
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk #(
  parameter int ADDR_W   = 12,
  parameter int MSG_BASE = 'h100,
  parameter int DB_OFF   = 'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [4:0]        status,
  input logic              rep_fatal,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr
);

  localparam logic [ADDR_W-1:0] DB_A   = ADDR_W'(DB_OFF);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(MSG_BASE + 16);

  a_r1_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r4_ring_after_last_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == DB_A) |->
      $past(bus_valid && bus_write && bus_addr == LAST_A));

  a_r10_fatal_only_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rep_fatal) |-> (status == 5'd0));

  a_r11_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  a_r12_bus_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid);

endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(
  .ADDR_W(ADDR_W), .MSG_BASE(MSG_BASE), .DB_OFF(DB_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .status(status), .rep_fatal(rep_fatal), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr)
);

// File: tb/mbox_cmd_seq_bench.sv
module mbox_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int PMAX = 6;
  localparam int PGAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] cmd_idx = '0;
  logic bus_valid, bus_write, busy, done, rep_msgram, rep_fatal;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rep_addr;
  logic [4:0] status;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_cmd_seq #(.ADDR_W(AW), .POLL_MAX(PMAX), .POLL_GAP(PGAP)) u_mbox_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .status(status), .rep_msgram(rep_msgram), .rep_fatal(rep_fatal),
    .rep_addr(rep_addr));

  // coprocessor and RAM model
  int          cfg_delay = 0;
  logic [31:0] cfg_resp = 32'd1;
  logic [31:0] cfg_words [5];
  logic [31:0] msgmem [5];
  int          pcount = 0;
  int          wn = 0, rn = 0, pn = 0;
  logic [AW-1:0] wl_addr [64];
  logic [31:0]   wl_data [64];

  wire in_msg = (bus_addr >= AW'('h100)) && (bus_addr < AW'('h114));
  wire [2:0] msg_i = 3'((bus_addr - AW'('h100)) >> 2);

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_addr == AW'('h14)) bus_rdata = (pcount >= cfg_delay) ? cfg_resp : 32'd0;
    else if (in_msg) bus_rdata = msgmem[msg_i];
  end

  always_ff @(posedge clk) begin
    if (bus_valid) begin
      if (bus_write) begin
        wl_addr[wn % 64] <= bus_addr;
        wl_data[wn % 64] <= bus_wdata;
        wn <= wn + 1;
        if (in_msg) msgmem[msg_i] <= bus_wdata;
        if (bus_addr == AW'('h10) && bus_wdata == 32'd1) begin
          pcount <= 0;
          for (int i = 0; i < 5; i++) msgmem[i] <= cfg_words[i];
        end
      end else if (bus_addr == AW'('h14)) begin
        pn <= pn + 1;
        pcount <= pcount + 1;
      end else begin
        rn <= rn + 1;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int c, input int i);
    logic [31:0] t [3][5] = '{'{1,1,1,1,4}, '{1,2,1,1,5}, '{1,2,1,2,6}};
    return t[c][i];
  endfunction

  function automatic int exp_code(input bit tout, input bit rej, input logic [31:0] resp, input bit badsum);
    if (tout) return 5;
    if (rej) return 2;
    if (badsum) return 3;
    if (resp == 32'd1) return 0;
    for (int i = 0; i < 31; i++) if (resp[i]) return i + 1;
    return 0;
  endfunction

  task automatic run(input int idx, input int delay, input logic [31:0] resp,
                     input logic [31:0] arg, input bit badsum, input bit inject);
    int w0, r0, p0, cyc, lat, ec, dones;
    bit rej, tout;
    logic [31:0] s;
    rej = (idx > 2);
    tout = (delay >= PMAX);
    cfg_delay = delay;
    cfg_resp = resp;
    cfg_words[0] = 32'd2; cfg_words[1] = 32'(idx); cfg_words[2] = 32'd1; cfg_words[3] = arg;
    s = cfg_words[0] + cfg_words[1] + cfg_words[2] + cfg_words[3];
    cfg_words[4] = badsum ? s + 32'd1 : s;
    lat = rej ? 2 : tout ? 10 + (PMAX - 1) * (1 + PGAP) : 15 + delay * (1 + PGAP);
    ec = exp_code(tout, rej, resp, badsum);
    @(negedge clk);
    w0 = wn; r0 = rn; p0 = pn;
    start = 1'b1; cmd_idx = 4'(idx);
    cyc = 0; dones = 0;
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (inject && cyc == 3) begin start = 1'b1; cmd_idx = 4'd0; end
      if (done) break;
      chk(!rej || busy == 1'b1, "R1", busy, 1);
    end
    chk(cyc == lat, "R11", cyc, lat);
    chk(status == 5'(ec), "R9", status, ec);
    if (ec == 0 && !tout && !rej) begin
      if (arg[31:28] == 4'd1) begin
        chk(rep_msgram && !rep_fatal && rep_addr == 32'h100 + {4'd0, arg[27:0]}, "R10", rep_addr, 32'h100 + {4'd0, arg[27:0]});
      end else if (arg[31:28] == 4'd0) begin
        chk(!rep_msgram && !rep_fatal && rep_addr == {4'd0, arg[27:0]}, "R10", rep_addr, {4'd0, arg[27:0]});
      end else begin
        chk(rep_fatal && !rep_msgram, "R10", rep_fatal, 1);
      end
    end else begin
      chk(!rep_msgram && !rep_fatal && rep_addr == 0, "R10", {rep_msgram, rep_fatal}, 0);
    end
    if (rej) begin
      chk(wn == w0 && rn == r0 && pn == p0, "R2", wn - w0 + rn - r0 + pn - p0, 0);
    end else begin
      chk(wn - w0 == 7, "R3", wn - w0, 7);
      for (int i = 0; i < 5; i++) begin
        chk(wl_addr[(w0 + i) % 64] == AW'('h100 + 4 * i), "R3", wl_addr[(w0 + i) % 64], 'h100 + 4 * i);
        chk(wl_data[(w0 + i) % 64] == exp_word(idx, i), "R3", wl_data[(w0 + i) % 64], exp_word(idx, i));
      end
      chk(wl_addr[(w0 + 5) % 64] == AW'('h10) && wl_data[(w0 + 5) % 64] == 1, "R4", wl_addr[(w0 + 5) % 64], 'h10);
      chk(wl_addr[(w0 + 6) % 64] == AW'('h14) && wl_data[(w0 + 6) % 64] == 0, "R7", wl_data[(w0 + 6) % 64], 0);
      chk(pn - p0 == (tout ? PMAX : delay + 1), tout ? "R6" : "R5", pn - p0, tout ? PMAX : delay + 1);
      chk(rn - r0 == (tout ? 0 : 5), tout ? "R6" : "R8", rn - r0, tout ? 0 : 5);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) dones++;
      chk(!bus_valid, "R12", bus_valid, 0);
    end
    if (inject) chk(dones == 0 && wn - w0 == 7, "R1", dones, 0);
    chk(status == 5'(ec), "R11", status, ec);
  endtask

  initial begin
    logic [31:0] resps [8] = '{32'h1, 32'h80000001, 32'h80000002, 32'h80000004,
                               32'h80000008, 32'h80000010, 32'h80000000, 32'h0000000C};
    logic [31:0] args [3] = '{32'h0000_0040, 32'h1000_0008, 32'h3000_0004};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_valid && status == 0, "R11", {busy, done, bus_valid}, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 3; c++)
      for (int d = 0; d < 3; d += 2)
        for (int r = 0; r < 8; r++)
          for (int a = 0; a < 3; a++)
            run(c, d, resps[r], args[a], 1'b0, 1'b0);
    for (int c = 0; c < 3; c++) run(c, 1, 32'h1, args[1], 1'b1, 1'b0);
    for (int c = 0; c < 3; c++) run(c, 1, 32'h80000002, args[0], 1'b1, 1'b0);
    for (int c = 0; c < 3; c++) run(c, PMAX + 10, 32'h1, args[0], 1'b0, 1'b0);
    run(0, PMAX - 1, 32'h1, args[1], 1'b0, 1'b0);
    for (int c = 3; c < 16; c++) run(c, 0, 32'h1, args[0], 1'b0, 1'b0);
    run(2, 1, 32'h1, args[1], 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule